// File: doc/BRIEF.md
# Multicycle 32-bit RISC core

This block is a small 32-bit processor core that runs each instruction as a series of clock steps. A single step controller works from the instruction's opcode. It drives one shared datapath: a program counter, an instruction register, two operand latches, an ALU result register and a memory data register, plus a 32-entry register file with two read ports and one write port. The core supports register-register arithmetic and logic, word load, word store, branch-if-equal and an absolute jump. Depending on its class, an instruction takes three, four or five cycles.

Instructions and data share one word-addressed memory array inside the block. Before reset is released, a loading port fills this memory with a program and its data. A read-only peek port returns any word at any time, so stored results can be inspected. A free-running cycle counter and a one-cycle completion flag let an observer measure the cycles each instruction takes. The register-file write port is also brought out for observation.

Top module: `mcpu_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0, `cycle_cnt_o` is 0 and `instr_done_o` is 0. The first clock after reset is released is a fetch step.
- R2: A fetch step loads the instruction register from memory word `pc_o[MEM_AW+1:2]` and advances `pc_o` by 4, so `pc_o` reads 4 one cycle after the first fetch.
- R3: An R-type instruction (opcode 0x00, sources in bits 25-21 and 20-16, destination in bits 15-11) takes 4 cycles. It writes the ALU result of the function field in bits 5-0 to the destination register: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 or 0).
- R4: A load (opcode 0x23) takes 5 cycles. It writes the memory word at byte address rs + sign-extended bits 15-0 into register rt (bits 20-16).
- R5: A store (opcode 0x2B) takes 4 cycles. It writes register rt to the memory word at byte address rs + sign-extended bits 15-0.
- R6: A branch-if-equal (opcode 0x04) takes 3 cycles. When rs equals rt, the next PC is the fetch address + 4 + (sign-extended bits 15-0 shifted left by 2). Otherwise it is the fetch address + 4.
- R7: A jump (opcode 0x02) takes 3 cycles. The next PC is bits 31-28 of the incremented PC, followed by bits 25-0 of the instruction and two zero bits.
- R8: Register 0 always reads as zero, and a write addressed to it has no effect.
- R9: `instr_done_o` is high exactly in the last cycle of each instruction. `cycle_cnt_o` increases by one every clock after reset.
- R10: Any other opcode takes 3 cycles and changes neither registers nor memory.
- R11: When `prog_we` is high, `prog_wdata` is written to memory word `prog_addr`, and this takes precedence over a core store. `peek_data` always shows memory word `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Memory load strobe |
| prog_addr | input | MEM_AW | Word index for loading |
| prog_wdata | input | 32 | Word to load |
| peek_addr | input | MEM_AW | Word index to observe |
| peek_data | output | 32 | Memory word at `peek_addr` |
| pc_o | output | 32 | Program counter |
| instr_done_o | output | 1 | High in an instruction's final cycle |
| cycle_cnt_o | output | 32 | Cycles since reset |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |

## Verification
The assertions rely on `prog_we` staying low while the core runs. They also rely on the program keeping its fetch and data addresses inside the memory array, so that the PC and the completion flag follow only the step sequence. The stimulus loads every word only while reset is held. Its program touches words 0 to 88 only, and it places random operands solely in data words. The two operands are forced to differ so that the not-taken branch stays not-taken.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} step_e;
    typedef enum logic [2:0] {CL_RTYPE, CL_LOAD, CL_STORE, CL_BEQ, CL_JUMP, CL_NONE} iclass_e;
    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} aluop_e;

    typedef struct packed {
        logic [5:0]      op;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [4:0]      sh;
        logic [5:0]      fn;
    } instr_t;

    typedef struct packed {
        logic ir_load;
        logic pc_inc;
        logic ab_load;
        logic calc_tgt;
        logic calc_addr;
        logic calc_r;
        logic br_en;
        logic jmp;
        logic mdr_load;
        logic mem_we;
        logic wr_rd;
        logic wr_rt;
        logic done;
    } ctrl_t;

    typedef struct packed {
        logic            we;
        logic [RIDX-1:0] addr;
        logic [XLEN-1:0] data;
    } rf_wr_t;

    function automatic iclass_e classify(input logic [5:0] op);
        case (op)
            OP_RTYPE: return CL_RTYPE;
            OP_LOAD:  return CL_LOAD;
            OP_STORE: return CL_STORE;
            OP_BEQ:   return CL_BEQ;
            OP_JUMP:  return CL_JUMP;
            default:  return CL_NONE;
        endcase
    endfunction

    function automatic aluop_e fn_to_alu(input logic [5:0] fn);
        case (fn)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
        return {{(XLEN-16){imm[15]}}, imm};
    endfunction
endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam int N = 1 << AW;
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aluop_e       op,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
    import mcpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    output step_e      step_o,
    output iclass_e    cls_o,
    output ctrl_t      ctl
);
    step_e   step_q, step_n;
    iclass_e cls;

    assign cls    = classify(opcode);
    assign cls_o  = cls;
    assign step_o = step_q;

    always_comb begin
        step_n = ST_FETCH;
        case (step_q)
            ST_FETCH:  step_n = ST_DECODE;
            ST_DECODE: step_n = ST_EXEC;
            ST_EXEC:   step_n = (cls inside {CL_RTYPE, CL_LOAD, CL_STORE}) ? ST_MEM : ST_FETCH;
            ST_MEM:    step_n = (cls == CL_LOAD) ? ST_WB : ST_FETCH;
            default:   step_n = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_FETCH;
        else     step_q <= step_n;
    end

    always_comb begin
        ctl = '0;
        case (step_q)
            ST_FETCH: begin
                ctl.ir_load = 1'b1;
                ctl.pc_inc  = 1'b1;
            end
            ST_DECODE: begin
                ctl.ab_load  = 1'b1;
                ctl.calc_tgt = 1'b1;
            end
            ST_EXEC: begin
                ctl.calc_addr = (cls == CL_LOAD) || (cls == CL_STORE);
                ctl.calc_r    = (cls == CL_RTYPE);
                ctl.br_en     = (cls == CL_BEQ);
                ctl.jmp       = (cls == CL_JUMP);
                ctl.done      = (cls inside {CL_BEQ, CL_JUMP, CL_NONE});
            end
            ST_MEM: begin
                ctl.mdr_load = (cls == CL_LOAD);
                ctl.mem_we   = (cls == CL_STORE);
                ctl.wr_rd    = (cls == CL_RTYPE);
                ctl.done     = (cls != CL_LOAD);
            end
            default: begin
                ctl.wr_rt = 1'b1;
                ctl.done  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [MEM_AW-1:0] prog_addr,
    input  logic [XLEN-1:0]   prog_wdata,
    input  logic [MEM_AW-1:0] peek_addr,
    output logic [XLEN-1:0]   peek_data,
    output logic [XLEN-1:0]   pc_o,
    output logic              instr_done_o,
    output logic [XLEN-1:0]   cycle_cnt_o,
    output logic              rf_we_o,
    output logic [RIDX-1:0]   rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o
);
    localparam int MEM_WORDS = 1 << MEM_AW;

    logic [XLEN-1:0] mem [MEM_WORDS];
    logic [XLEN-1:0] pc, aluout, a_q, b_q, mdr, cyc;
    instr_t          ir;
    step_e           step;
    iclass_e         cls;
    ctrl_t           ctl;
    rf_wr_t          wr;
    logic [XLEN-1:0] rd1, rd2, alu_b, alu_y, imm_ext;
    aluop_e          alu_op;
    logic [MEM_AW-1:0] pc_idx, dat_idx;

    assign imm_ext = sext16({ir.rd, ir.sh, ir.fn});
    assign pc_idx  = pc[MEM_AW+1:2];
    assign dat_idx = aluout[MEM_AW+1:2];

    mcpu_ctrl u_ctrl (
        .clk(clk), .rst(rst), .opcode(ir.op),
        .step_o(step), .cls_o(cls), .ctl(ctl)
    );

    mcpu_regfile #(.W(XLEN), .AW(RIDX)) u_rf (
        .clk(clk), .rst(rst),
        .ra1(ir.rs), .ra2(ir.rt), .rd1(rd1), .rd2(rd2),
        .we(wr.we), .wa(wr.addr), .wd(wr.data)
    );

    assign alu_op = ctl.calc_r ? fn_to_alu(ir.fn) : ALU_ADD;
    assign alu_b  = ctl.calc_r ? b_q : imm_ext;

    mcpu_alu #(.W(XLEN)) u_alu (
        .a(a_q), .b(alu_b), .op(alu_op), .y(alu_y)
    );

    always_comb begin
        wr.we   = ctl.wr_rd | ctl.wr_rt;
        wr.addr = ctl.wr_rd ? ir.rd : ir.rt;
        wr.data = ctl.wr_rd ? aluout : mdr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            a_q    <= '0;
            b_q    <= '0;
            aluout <= '0;
            mdr    <= '0;
            cyc    <= '0;
        end else begin
            cyc <= cyc + 1'b1;
            if (ctl.ir_load) ir <= instr_t'(mem[pc_idx]);
            if (ctl.pc_inc)  pc <= pc + 32'd4;
            if (ctl.ab_load) begin
                a_q <= rd1;
                b_q <= rd2;
            end
            if (ctl.calc_tgt) aluout <= pc + {imm_ext[XLEN-3:0], 2'b00};
            if (ctl.calc_addr || ctl.calc_r) aluout <= alu_y;
            if (ctl.br_en && (a_q == b_q)) pc <= aluout;
            if (ctl.jmp) pc <= {pc[31:28], ir.rs, ir.rt, ir.rd, ir.sh, ir.fn, 2'b00};
            if (ctl.mdr_load) mdr <= mem[dat_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (prog_we)         mem[prog_addr] <= prog_wdata;
        else if (ctl.mem_we) mem[dat_idx]   <= b_q;
    end

    assign peek_data    = mem[peek_addr];
    assign pc_o         = pc;
    assign cycle_cnt_o  = cyc;
    assign instr_done_o = ctl.done & ~rst;
    assign rf_we_o      = wr.we;
    assign rf_waddr_o   = wr.addr;
    assign rf_wdata_o   = wr.data;
endmodule

// File: rtl/mcpu_chk.sv
module mcpu_chk
    import mcpu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input step_e       step,
    input logic [31:0] pc,
    input logic [31:0] cyc,
    input logic        done,
    input logic [4:0]  rs_idx,
    input logic [31:0] a_val
);
    // R2
    fetch_adv_chk: assert property (@(posedge clk) disable iff (rst)
        step == ST_FETCH |=> pc == $past(pc) + 32'd4);

    // R6
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step == ST_DECODE || step == ST_MEM || step == ST_WB) |=> $stable(pc));

    // R9
    cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
        cyc != 32'hFFFF_FFFF |=> cyc == $past(cyc) + 32'd1);

    // R9
    done_refetch_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> step == ST_FETCH);

    // R8
    zero_src_chk: assert property (@(posedge clk) disable iff (rst)
        (step == ST_DECODE && rs_idx == 5'd0) |=> a_val == 32'd0);
endmodule

bind mcpu_core mcpu_chk u_chk (
    .clk(clk), .rst(rst), .step(step), .pc(pc), .cyc(cyc),
    .done(instr_done_o), .rs_idx(ir.rs), .a_val(a_q)
);

// File: tb/tb_mcpu_core.sv
module tb_mcpu_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [31:0] prog_wdata = '0;
    logic [7:0]  peek_addr = '0;
    logic [31:0] peek_data, pc_o, cycle_cnt_o, rf_wdata_o;
    logic        instr_done_o, rf_we_o;
    logic [4:0]  rf_waddr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mcpu_core dut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .peek_addr(peek_addr), .peek_data(peek_data),
        .pc_o(pc_o), .instr_done_o(instr_done_o), .cycle_cnt_o(cycle_cnt_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(int widx);
        return {6'h02, widx[25:0]};
    endfunction
    function automatic logic [31:0] sentinel(int w);
        return 32'hA5A5_0000 | w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(int w, logic [31:0] v);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = w[7:0]; prog_wdata = v;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic peek_chk(string tag, int w, logic [31:0] exp);
        peek_addr = w[7:0];
        #1;
        check(tag, peek_data, exp);
    endtask

    task automatic run_case(logic [31:0] d0, logic [31:0] d1);
        logic [31:0] prog [24];
        int seq [21];
        int cpi [21];
        string tg [21];
        int k, prev, ndone, wd;
        logic slt;
        prog[0]  = enc_i(6'h23, 0, 1, 256);
        prog[1]  = enc_i(6'h23, 0, 2, 260);
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_r(1, 2, 4, 6'h22);
        prog[4]  = enc_r(1, 2, 5, 6'h24);
        prog[5]  = enc_r(1, 2, 6, 6'h25);
        prog[6]  = enc_r(1, 2, 7, 6'h2A);
        prog[7]  = enc_r(1, 2, 0, 6'h20);
        prog[8]  = enc_r(0, 0, 8, 6'h20);
        for (int i = 0; i < 6; i++) prog[9+i] = enc_i(6'h2B, 0, 3+i, 320 + 4*i);
        prog[15] = enc_i(6'h04, 1, 1, 1);
        prog[16] = enc_i(6'h2B, 0, 1, 344);
        prog[17] = enc_i(6'h04, 1, 2, 1);
        prog[18] = enc_i(6'h2B, 0, 2, 348);
        prog[19] = enc_j(22);
        prog[20] = enc_i(6'h2B, 0, 1, 352);
        prog[21] = enc_i(6'h2B, 0, 1, 352);
        prog[22] = {6'h3F, 26'h3FF_FFFF};
        prog[23] = enc_i(6'h04, 0, 0, -1);
        k = 0;
        for (int i = 0; i < 24; i++) begin
            if (i == 16 || i == 20 || i == 21) continue;
            seq[k] = i; k++;
        end
        for (int i = 0; i < 21; i++) begin
            case (prog[seq[i]][31:26])
                6'h23:   begin cpi[i] = 5; tg[i] = "R4/R9 load cycles"; end
                6'h00:   begin cpi[i] = 4; tg[i] = "R3/R9 rtype cycles"; end
                6'h2B:   begin cpi[i] = 4; tg[i] = "R5/R9 store cycles"; end
                6'h04:   begin cpi[i] = 3; tg[i] = "R6/R9 branch cycles"; end
                6'h02:   begin cpi[i] = 3; tg[i] = "R7/R9 jump cycles"; end
                default: begin cpi[i] = 3; tg[i] = "R10 unsupported cycles"; end
            endcase
        end
        rst = 1'b1;
        for (int i = 0; i < 24; i++) load(i, prog[i]);
        load(64, d0);
        load(65, d1);
        for (int w = 80; w <= 88; w++) load(w, sentinel(w));
        @(negedge clk);
        check("R1 pc in reset", pc_o, 32'd0);
        check("R1 cycles in reset", cycle_cnt_o, 32'd0);
        check("R1 done in reset", {31'd0, instr_done_o}, 32'd0);
        peek_chk("R11 loaded word", 64, d0);
        rst = 1'b0;
        prev = -1; ndone = 0; wd = 0;
        while (ndone < 21 && wd < 2000) begin
            @(negedge clk);
            wd++;
            if (cycle_cnt_o == 32'd1) check("R2 pc after first fetch", pc_o, 32'd4);
            if (instr_done_o) begin
                check(tg[ndone], cycle_cnt_o - prev, cpi[ndone]);
                prev = int'(cycle_cnt_o);
                ndone++;
            end
        end
        if (wd >= 2000) check("R9 watchdog expired", 32'd0, 32'd1);
        @(negedge clk);
        check("R6 backward branch target", pc_o, 32'd92);
        slt = $signed(d0) < $signed(d1);
        peek_chk("R3 add", 80, d0 + d1);
        peek_chk("R3 sub", 81, d0 - d1);
        peek_chk("R3 and", 82, d0 & d1);
        peek_chk("R3 or", 83, d0 | d1);
        peek_chk("R3 slt", 84, {31'd0, slt});
        peek_chk("R8 zero register", 85, 32'd0);
        peek_chk("R6 taken branch skips", 86, sentinel(86));
        peek_chk("R6 not-taken falls through", 87, d1);
        peek_chk("R7 jump skips", 88, sentinel(88));
    endtask

    initial begin
        logic [31:0] x, y;
        void'($urandom(32'd411));
        run_case(32'h7FFF_FFFF, 32'h8000_0000);
        run_case(32'h0000_0000, 32'hFFFF_FFFF);
        for (int r = 0; r < 3; r++) begin
            x = $urandom();
            y = $urandom();
            if (x == y) y = y ^ 32'd1;
            run_case(x, y);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule